// File: doc/BRIEF.md
# Dual Reloadable Timer with Watchdog

This block holds two independent down-counting timers and a watchdog, all reached through one small register port. Each timer has a control word, a live count and a reload value. It counts down once per tick of a prescaled version of the core clock. When it reaches terminal count it raises its own flag and a bit in a shared status word, and the status word feeds one interrupt line. A timer either reloads itself and keeps running, or disables itself and stops.

The watchdog is dormant after reset. Software arms it by writing two key words, one after the other, to its control address. Once armed it counts core clock cycles down from a fixed load value and emits a one-cycle reset pulse when it expires. Writing the key pair again restarts its count. Nothing disarms it short of a reset.

The register port is a single-cycle write strobe with a 3-bit word address. The read data is registered, so it shows the addressed word one cycle after the address is presented.

Top module: `dual_timer_wdog`

## Requirements
- R1: After reset, every register reads zero, `irq` and `wdog_rst` are low and the watchdog is unarmed.
- R2: The word addresses are 0/1 control of timer 0/1, 2/3 count, 4/5 reload, 6 status and 7 watchdog. In a control word, bit 0 is the terminal flag, bit 1 is enable, bit 2 is auto-reload and bits 5:4 pick the tick divider: 0 is /1, 1 is /4, 2 is /8 and 3 is /16. A timer enabled with count C and divider D by a write at clock edge E reaches terminal count at edge E + C·D.
- R3: At terminal count, timer n sets its control bit 0 and status bit n. A set takes priority over a clear in the same cycle.
- R4: At terminal count with auto-reload clear, the timer clears its enable bit and leaves its count at 0.
- R5: At terminal count with auto-reload set, the count is loaded from the reload register and the timer keeps running, so it reaches terminal count every reload·D edges.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Writing 1 to control bit 0 clears the terminal flag.
- R7: `irq` is the OR of the status bits, registered, so it follows the status word one cycle later.
- R8: Writing 0x1E1E1E1E and then 0xE1E1E1E1 to address 7, on consecutive writes, arms the watchdog. Address 7 reads 1 in bit 0 once the watchdog is armed.
- R9: Any write between the two key words, other than the second key itself, discards the first key.
- R10: An armed watchdog stays armed, whatever is written. Writing the key pair again reloads its count.
- R11: A watchdog armed or reloaded at edge A, with load L, drives `wdog_rst` high for exactly one cycle, starting at edge A + L + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for `addr` |
| irq | output | 1 | Timer interrupt, OR of the status bits |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
Timer 0 runs as a one-shot under every divider setting, with counts of 1, 2 and 5. The exact edge at which the interrupt rises separates a wrong divider from an off-by-one in the prescaler or in the terminal detection. A run of timer 1 with the slowest divider and auto-reload shows that the reload value, not the start count, sets the period. Both timers expiring together, then being cleared one bit at a time, tells the OR of the interrupt apart from a single-bit source. The watchdog is given broken key sequences and a valid one, then a disarm attempt and a re-keying, so that arming, key discard and count reload each show in the timing of the pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int NUM_TMR = 2;

  localparam logic [ADDR_W-1:0] A_CTRL0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT0   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD0   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd6;
  localparam logic [ADDR_W-1:0] A_WDOG   = 3'd7;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h1E1E_1E1E;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'hE1E1_E1E1;

  localparam int B_TC   = 0;
  localparam int B_EN   = 1;
  localparam int B_AUTO = 2;
  localparam int B_DIVL = 4;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int CH    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  rld_q,
  output logic              term_evt
);
  localparam logic [ADDR_W-1:0] MY_CTRL = A_CTRL0 + ADDR_W'(CH);
  localparam logic [ADDR_W-1:0] MY_CNT  = A_CNT0 + ADDR_W'(CH);
  localparam logic [ADDR_W-1:0] MY_RLD  = A_RLD0 + ADDR_W'(CH);

  logic       tc_q, en_q, auto_q;
  logic [1:0] div_q;
  logic [3:0] psc_q, psc_mask;
  logic       tick;

  always_comb begin
    case (div_q)
      2'd0: psc_mask = 4'h0;
      2'd1: psc_mask = 4'h3;
      2'd2: psc_mask = 4'h7;
      default: psc_mask = 4'hF;
    endcase
  end

  assign tick     = en_q && ((psc_q & psc_mask) == psc_mask);
  assign term_evt = tick && (cnt_q <= CNT_W'(1));
  assign ctrl_word = {{(DATA_W-6){1'b0}}, div_q, 1'b0, auto_q, en_q, tc_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q <= 1'b0; en_q <= 1'b0; auto_q <= 1'b0; div_q <= 2'd0;
      psc_q <= 4'd0; cnt_q <= '0; rld_q <= '0;
    end else begin
      psc_q <= en_q ? psc_q + 4'd1 : 4'd0;
      if (tick) cnt_q <= term_evt ? (auto_q ? rld_q : '0) : cnt_q - CNT_W'(1);
      if (term_evt && !auto_q) en_q <= 1'b0;
      if (wr_en && addr == MY_CTRL) begin
        en_q   <= wdata[B_EN];
        auto_q <= wdata[B_AUTO];
        div_q  <= wdata[B_DIVL+1:B_DIVL];
        psc_q  <= 4'd0;
        if (wdata[B_TC]) tc_q <= 1'b0;
      end
      if (term_evt) tc_q <= 1'b1;
      if (wr_en && addr == MY_CNT) cnt_q <= wdata[CNT_W-1:0];
      if (wr_en && addr == MY_RLD) rld_q <= wdata[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/wdog_unit.sv
module wdog_unit
  import tmr_pkg::*;
#(
  parameter int LOAD = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed,
  output logic              pulse
);
  localparam int WCW = $clog2(LOAD + 1);

  logic           half_q;
  logic [WCW-1:0] cnt_q;
  logic           key_wr;

  assign key_wr = wr_en && (addr == A_WDOG);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0; pulse <= 1'b0; half_q <= 1'b0; cnt_q <= '0;
    end else begin
      pulse <= armed && (cnt_q == '0);
      if (armed) cnt_q <= (cnt_q == '0) ? WCW'(LOAD) : cnt_q - WCW'(1);
      if (wr_en) begin
        if (key_wr && half_q && wdata == KEY_SECOND) begin
          armed  <= 1'b1;
          cnt_q  <= WCW'(LOAD);
          half_q <= 1'b0;
        end else begin
          half_q <= key_wr && (wdata == KEY_FIRST);
        end
      end
    end
  end
endmodule

// File: rtl/dual_timer_wdog.sv
module dual_timer_wdog
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int WDOG_LOAD = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              wdog_rst
);
  logic [DATA_W-1:0]  ctrl_v [NUM_TMR];
  logic [CNT_W-1:0]   cnt_v  [NUM_TMR];
  logic [CNT_W-1:0]   rld_v  [NUM_TMR];
  logic [NUM_TMR-1:0] term_v;
  logic [NUM_TMR-1:0] status_q;
  logic               wd_armed;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    tmr_channel #(.CNT_W(CNT_W), .CH(g)) u_chan (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .ctrl_word(ctrl_v[g]), .cnt_q(cnt_v[g]), .rld_q(rld_v[g]),
      .term_evt(term_v[g])
    );

    always_ff @(posedge clk) begin
      if (rst) status_q[g] <= 1'b0;
      else if (term_v[g]) status_q[g] <= 1'b1;
      else if (wr_en && addr == A_STATUS && wdata[g]) status_q[g] <= 1'b0;
    end
  end

  wdog_unit #(.LOAD(WDOG_LOAD)) u_wdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .armed(wd_armed), .pulse(wdog_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      irq <= |status_q;
      case (addr)
        3'd0:    rdata <= ctrl_v[0];
        3'd1:    rdata <= ctrl_v[1];
        3'd2:    rdata <= DATA_W'(cnt_v[0]);
        3'd3:    rdata <= DATA_W'(cnt_v[1]);
        3'd4:    rdata <= DATA_W'(rld_v[0]);
        3'd5:    rdata <= DATA_W'(rld_v[1]);
        3'd6:    rdata <= DATA_W'(status_q);
        default: rdata <= DATA_W'(wd_armed);
      endcase
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic [1:0] status,
  input logic [1:0] term,
  input logic       armed,
  input logic       wdog_rst
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!irq && !wdog_rst && !armed));
  // R3
  term0_sets_status_chk: assert property (@(posedge clk) disable iff (rst) term[0] |=> status[0]);
  // R3
  term1_sets_status_chk: assert property (@(posedge clk) disable iff (rst) term[1] |=> status[1]);
  // R7
  irq_high_chk: assert property (@(posedge clk) disable iff (rst) (|status) |=> irq);
  // R7
  irq_low_chk: assert property (@(posedge clk) disable iff (rst) !(|status) |=> !irq);
  // R10
  stay_armed_chk: assert property (@(posedge clk) disable iff (rst) armed |=> armed);
  // R11
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst) wdog_rst |=> !wdog_rst);
  // R11
  pulse_needs_arm_chk: assert property (@(posedge clk) disable iff (rst) wdog_rst |-> armed);
endmodule

bind dual_timer_wdog tmr_chk u_chk (
  .clk(clk), .rst(rst), .irq(irq), .status(status_q), .term(term_v),
  .armed(wd_armed), .wdog_rst(wdog_rst)
);

// File: tb/dual_timer_wdog_bench.sv
`timescale 1ns/1ps
module dual_timer_wdog_bench;
  import tmr_pkg::*;
  localparam int L = 40;

  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wdog_rst;

  dual_timer_wdog #(.CNT_W(16), .WDOG_LOAD(L)) u_dual_timer_wdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst)
  );

  always #10 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk); addr = 3'(a);
    @(negedge clk); v = rdata;
  endtask

  task automatic wait_irq(output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) begin at = cyc; break; end
    end
  endtask

  task automatic wait_pulse(output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (wdog_rst) begin at = cyc; break; end
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int e, at, a, npulse;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int r = 0; r < 8; r++) begin
      rd(r, v); chk($sformatf("R1 reg%0d", r), v, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 wdog_rst", wdog_rst, 0);

    // R2 R3 R4 R6 R7: one-shot sweep over dividers and counts
    for (int cs = 0; cs < 4; cs++) begin
      for (int ci = 0; ci < 3; ci++) begin
        int c, d;
        c = (ci == 0) ? 1 : (ci == 1) ? 2 : 5;
        d = (cs == 0) ? 1 : (1 << (cs + 1));
        wr(2, c);
        wr(0, (cs << 4) | 2);
        e = cyc;
        wait_irq(at);
        chk($sformatf("R2 irq edge div%0d cnt%0d", d, c), at, e + c * d + 1);
        rd(6, v); chk("R3 status bit0", v, 1);
        rd(0, v); chk("R4 ctrl en cleared tc set", v, (cs << 4) | 1);
        rd(2, v); chk("R4 count at zero", v, 0);
        wr(6, 0);
        rd(6, v); chk("R6 zero write ignored", v, 1);
        wr(6, 1);
        rd(6, v); chk("R6 status cleared", v, 0);
        chk("R7 irq low after clear", irq, 0);
        wr(0, 1);
        rd(0, v); chk("R6 tc cleared", v, 0);
      end
    end

    // R5: auto-reload on timer 1, divider /16, start 2, reload 3
    wr(5, 3);
    wr(3, 2);
    wr(1, 32'h36);
    e = cyc;
    wait_irq(at);
    chk("R5 first terminal", at, e + 2 * 16 + 1);
    rd(1, v); chk("R5 still enabled", v, 32'h37);
    wr(6, 2);
    wait_irq(at);
    chk("R5 reload period", at, e + 2 * 16 + 3 * 16 + 1);
    wr(1, 0);
    wr(6, 2);
    wr(1, 1);

    // R3 R7: both timers expire, cleared one bit at a time
    wr(2, 3);
    wr(3, 6);
    wr(0, 2);
    wr(1, 2);
    repeat (12) @(negedge clk);
    rd(6, v); chk("R3 both status bits", v, 3);
    chk("R7 irq both", irq, 1);
    wr(6, 1);
    rd(6, v); chk("R6 only bit0 cleared", v, 2);
    chk("R7 irq from bit1", irq, 1);
    wr(6, 2);
    rd(6, v); chk("R6 bit1 cleared", v, 0);
    chk("R7 irq low", irq, 0);
    wr(0, 1);
    wr(1, 1);

    // R9: broken key sequences
    wr(7, KEY_FIRST); wr(2, 5); wr(7, KEY_SECOND);
    rd(7, v); chk("R9 other address discards key", v, 0);
    wr(7, KEY_FIRST); wr(7, 0); wr(7, KEY_SECOND);
    rd(7, v); chk("R9 wrong word discards key", v, 0);
    npulse = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (wdog_rst) npulse++; end
    chk("R9 no pulse while unarmed", npulse, 0);

    // R8 R11: arm and time the pulse
    wr(7, KEY_FIRST);
    wr(7, KEY_SECOND);
    a = cyc;
    rd(7, v); chk("R8 armed", v, 1);
    wait_pulse(at);
    chk("R11 pulse edge", at, a + L + 1);
    @(negedge clk); chk("R11 pulse one cycle", wdog_rst, 0);

    // R10: disarm attempt, then re-key reloads
    wr(7, 0);
    rd(7, v); chk("R10 still armed", v, 1);
    wr(7, KEY_FIRST);
    wr(7, KEY_SECOND);
    a = cyc;
    wait_pulse(at);
    chk("R10 re-key reloads count", at, a + L + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule